// File: doc/BRIEF.md
# Thread Block Dispatcher with Per-Core Resource Check

This block takes one kernel launch at a time and hands its thread blocks out, one per clock at most, to a fixed set of compute cores. A launch carries a grid size and a block size, each with three axes. It also gives the number of registers every thread needs and the amount of shared memory every block needs. All blocks of a launch are the same size. A block always goes whole onto one core, and only onto a core whose free register count and free shared memory can hold it entirely.

For every core the dispatcher keeps a ledger of free registers, free shared memory and the blocks still running there. Placing a block takes its cost off that core's ledger. A completion pulse from the core gives the cost back. Each placed block is labelled with a three-axis block index. Indices are walked with x changing fastest, then y, then z. When every block has been placed and every core has drained, the launch is reported finished and a new launch may be accepted. A launch that no single empty core could ever hold is turned away at once.

Top module: `bd_dispatcher`

## Requirements
- R1: After reset the block is idle: `busy` is 0, and `disp_valid`, `launch_done` and `launch_error` are 0.
- R2: Block indices are issued in the order x fastest, then y, then z. Every issued index is below the grid size on its axis. The first index is (0,0,0) and the last is (grid-1) on every axis.
- R3: A block is placed on a core only if that core's free register count is at least blk_x*blk_y*blk_z*regs_per_thread.
- R4: A block is placed on a core only if that core's free shared memory is at least shm_per_block.
- R5: While running, if any core fits the block, `disp_valid` is 1 in that same cycle and `disp_core` is the lowest-numbered fitting core (core 0 has the highest priority). If no core fits, no block is issued until a completion frees enough room.
- R6: A placement lowers the chosen core's free counters by the block cost at the clock edge. An accepted completion raises them by the same amount. Both may hit one core in the same cycle, and the effect of each depends only on the counters at the start of that cycle.
- R7: A launch is rejected when the block's register need exceeds CORE_REGS, or its shared memory exceeds CORE_SHM, or any of the six dimensions is zero. A rejected launch makes `launch_error` 1 for exactly the next cycle, issues no block, and leaves the block idle.
- R8: `launch_done` is 1 for one cycle once the last block has been issued and no core holds an outstanding block. In the next cycle `busy` is 0.
- R9: A completion pulse on a core with no outstanding block has no effect. A `launch_valid` pulse while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Offers a launch; accepted only while idle |
| grid_x | input | GDIM_W | Grid size, x axis |
| grid_y | input | GDIM_W | Grid size, y axis |
| grid_z | input | GDIM_W | Grid size, z axis |
| blk_x | input | BDIM_W | Threads per block, x axis |
| blk_y | input | BDIM_W | Threads per block, y axis |
| blk_z | input | BDIM_W | Threads per block, z axis |
| regs_per_thread | input | RPT_W | Registers needed by each thread |
| shm_per_block | input | SHM_W | Shared memory needed by each block |
| core_done | input | NUM_CORES | One pulse per finished block, one bit per core |
| busy | output | 1 | A launch is in progress |
| launch_error | output | 1 | One-cycle flag for a rejected launch |
| disp_valid | output | 1 | A block is placed in this cycle |
| disp_core | output | CIDX_W | Core receiving the block |
| disp_bx | output | GDIM_W | Block index, x |
| disp_by | output | GDIM_W | Block index, y |
| disp_bz | output | GDIM_W | Block index, z |
| launch_done | output | 1 | One-cycle flag when the launch has fully finished |

## Verification
The bench aims at blocks that fill a core's register budget exactly. An off-by-one fit test there would either never place the block or place one too many on a core. It mixes completions that land on the same core in the cycle it receives a new block. A ledger that handles only one of the two updates in that cycle drifts, and the placement stream then departs from the reference. Its launches are rejected by register size, by shared memory and by a zero axis, and it sends completion pulses to cores with nothing running. A design that accepts such a launch, or counts such a pulse, issues blocks or finishes the launch in the wrong cycle. Three-axis grids check the order of the index walk and its wrap, and early launch pulses during a run check that the current launch is not disturbed.

// File: rtl/bd_pkg.sv
package bd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } bd_state_e;

  // register cost of one whole block
  function automatic int unsigned block_regs(input int unsigned bx, input int unsigned by,
                                             input int unsigned bz, input int unsigned rpt);
    return bx * by * bz * rpt;
  endfunction

  // does a block of this cost fit in the given free room
  function automatic logic room_fits(input int unsigned free_r, input int unsigned need_r,
                                     input int unsigned free_s, input int unsigned need_s);
    return (free_r >= need_r) && (free_s >= need_s);
  endfunction

endpackage

// File: rtl/bd_core_ledger.sv
module bd_core_ledger #(
  parameter int NEED_W    = 18,
  parameter int SHM_W     = 10,
  parameter int OUT_W     = 13,
  parameter int CORE_REGS = 1024,
  parameter int CORE_SHM  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              give,
  input  logic [NEED_W-1:0] need_regs,
  input  logic [SHM_W-1:0]  need_shm,
  output logic [NEED_W-1:0] free_regs,
  output logic [SHM_W-1:0]  free_shm,
  output logic              fits,
  output logic              ret_ok,
  output logic              empty
);
  localparam logic [NEED_W-1:0] REGS_FULL = NEED_W'(CORE_REGS);
  localparam logic [SHM_W-1:0]  SHM_FULL  = SHM_W'(CORE_SHM);

  logic [OUT_W-1:0]  outstanding;
  logic [NEED_W-1:0] regs_dn, regs_up;
  logic [SHM_W-1:0]  shm_dn, shm_up;

  assign empty  = (outstanding == '0);
  assign ret_ok = give && !empty;
  assign fits   = bd_pkg::room_fits(int'(free_regs), int'(need_regs),
                                    int'(free_shm), int'(need_shm));

  assign regs_dn = take   ? need_regs : '0;
  assign regs_up = ret_ok ? need_regs : '0;
  assign shm_dn  = take   ? need_shm  : '0;
  assign shm_up  = ret_ok ? need_shm  : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_regs   <= REGS_FULL;
      free_shm    <= SHM_FULL;
      outstanding <= '0;
    end else begin
      free_regs <= free_regs - regs_dn + regs_up;
      free_shm  <= free_shm - shm_dn + shm_up;
      case ({take, ret_ok})
        2'b10:   outstanding <= outstanding + 1'b1;
        2'b01:   outstanding <= outstanding - 1'b1;
        default: outstanding <= outstanding;
      endcase
    end
  end
endmodule

// File: rtl/bd_pick.sv
module bd_pick #(
  parameter int NUM_CORES = 4,
  parameter int CIDX_W    = 2
) (
  input  logic [NUM_CORES-1:0] req,
  output logic [NUM_CORES-1:0] grant,
  output logic [CIDX_W-1:0]    idx,
  output logic                 any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = CIDX_W'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/bd_id_walker.sv
module bd_id_walker #(
  parameter int GDIM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [GDIM_W-1:0] gx,
  input  logic [GDIM_W-1:0] gy,
  input  logic [GDIM_W-1:0] gz,
  output logic [GDIM_W-1:0] ix,
  output logic [GDIM_W-1:0] iy,
  output logic [GDIM_W-1:0] iz,
  output logic              last
);
  logic x_end, y_end, z_end;

  assign x_end = (ix == gx - 1'b1);
  assign y_end = (iy == gy - 1'b1);
  assign z_end = (iz == gz - 1'b1);
  assign last  = x_end && y_end && z_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ix <= '0;
      iy <= '0;
      iz <= '0;
    end else if (clear) begin
      ix <= '0;
      iy <= '0;
      iz <= '0;
    end else if (step) begin
      if (!x_end) begin
        ix <= ix + 1'b1;
      end else begin
        ix <= '0;
        if (!y_end) begin
          iy <= iy + 1'b1;
        end else begin
          iy <= '0;
          iz <= z_end ? '0 : iz + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bd_dispatcher.sv
module bd_dispatcher #(
  parameter int NUM_CORES = 4,
  parameter int GDIM_W    = 4,
  parameter int BDIM_W    = 4,
  parameter int RPT_W     = 6,
  parameter int SHM_W     = 10,
  parameter int CORE_REGS = 1024,
  parameter int CORE_SHM  = 512,
  localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int NEED_W   = 3 * BDIM_W + RPT_W,
  localparam int OUT_W    = 3 * GDIM_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  input  logic [GDIM_W-1:0]    grid_x,
  input  logic [GDIM_W-1:0]    grid_y,
  input  logic [GDIM_W-1:0]    grid_z,
  input  logic [BDIM_W-1:0]    blk_x,
  input  logic [BDIM_W-1:0]    blk_y,
  input  logic [BDIM_W-1:0]    blk_z,
  input  logic [RPT_W-1:0]     regs_per_thread,
  input  logic [SHM_W-1:0]     shm_per_block,
  input  logic [NUM_CORES-1:0] core_done,
  output logic                 busy,
  output logic                 launch_error,
  output logic                 disp_valid,
  output logic [CIDX_W-1:0]    disp_core,
  output logic [GDIM_W-1:0]    disp_bx,
  output logic [GDIM_W-1:0]    disp_by,
  output logic [GDIM_W-1:0]    disp_bz,
  output logic                 launch_done
);
  import bd_pkg::*;

  bd_state_e state;
  logic [GDIM_W-1:0] gx_q, gy_q, gz_q;
  logic [NEED_W-1:0] need_regs_q, need_regs_in;
  logic [SHM_W-1:0]  need_shm_q;
  logic              err_q;
  logic              dims_ok, launch_ok, id_last, all_idle, any_fit;

  logic [NUM_CORES-1:0]             fit_vec, grant, take, ret_vec, idle_vec;
  logic [NUM_CORES-1:0][NEED_W-1:0] free_regs;
  logic [NUM_CORES-1:0][SHM_W-1:0]  free_shm;

  assign need_regs_in = NEED_W'(block_regs(int'(blk_x), int'(blk_y), int'(blk_z),
                                           int'(regs_per_thread)));
  assign dims_ok   = (grid_x != '0) && (grid_y != '0) && (grid_z != '0) &&
                     (blk_x != '0) && (blk_y != '0) && (blk_z != '0);
  assign launch_ok = dims_ok && room_fits(CORE_REGS, int'(need_regs_in),
                                          CORE_SHM, int'(shm_per_block));

  assign busy         = (state != ST_IDLE);
  assign launch_error = err_q;
  assign disp_valid   = (state == ST_RUN) && any_fit;
  assign all_idle     = &idle_vec;
  assign launch_done  = (state == ST_DRAIN) && all_idle;
  assign take         = disp_valid ? grant : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      err_q       <= 1'b0;
      gx_q        <= '0;
      gy_q        <= '0;
      gz_q        <= '0;
      need_regs_q <= '0;
      need_shm_q  <= '0;
    end else begin
      err_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch_valid) begin
            if (launch_ok) begin
              gx_q        <= grid_x;
              gy_q        <= grid_y;
              gz_q        <= grid_z;
              need_regs_q <= need_regs_in;
              need_shm_q  <= shm_per_block;
              state       <= ST_RUN;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_RUN:   if (disp_valid && id_last) state <= ST_DRAIN;
        ST_DRAIN: if (all_idle) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    bd_core_ledger #(
      .NEED_W(NEED_W), .SHM_W(SHM_W), .OUT_W(OUT_W),
      .CORE_REGS(CORE_REGS), .CORE_SHM(CORE_SHM)
    ) u_ledger (
      .clk(clk), .rst_n(rst_n),
      .take(take[c]), .give(core_done[c]),
      .need_regs(need_regs_q), .need_shm(need_shm_q),
      .free_regs(free_regs[c]), .free_shm(free_shm[c]),
      .fits(fit_vec[c]), .ret_ok(ret_vec[c]), .empty(idle_vec[c])
    );
  end

  bd_pick #(.NUM_CORES(NUM_CORES), .CIDX_W(CIDX_W)) u_pick (
    .req(fit_vec), .grant(grant), .idx(disp_core), .any(any_fit)
  );

  bd_id_walker #(.GDIM_W(GDIM_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .clear(state == ST_IDLE), .step(disp_valid),
    .gx(gx_q), .gy(gy_q), .gz(gz_q),
    .ix(disp_bx), .iy(disp_by), .iz(disp_bz), .last(id_last)
  );
endmodule

// File: rtl/bd_dispatcher_chk.sv
module bd_dispatcher_chk #(
  parameter int NUM_CORES = 4,
  parameter int GDIM_W    = 4,
  parameter int SHM_W     = 10,
  parameter int NEED_W    = 18,
  parameter int CIDX_W    = 2,
  parameter int CORE_REGS = 1024,
  parameter int CORE_SHM  = 512
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             busy,
  input logic                             launch_error,
  input logic                             disp_valid,
  input logic [CIDX_W-1:0]                disp_core,
  input logic [GDIM_W-1:0]                disp_bx,
  input logic [GDIM_W-1:0]                disp_by,
  input logic [GDIM_W-1:0]                disp_bz,
  input logic                             launch_done,
  input logic [GDIM_W-1:0]                gx_q,
  input logic [GDIM_W-1:0]                gy_q,
  input logic [GDIM_W-1:0]                gz_q,
  input logic [NEED_W-1:0]                need_regs_q,
  input logic [SHM_W-1:0]                 need_shm_q,
  input logic [NUM_CORES-1:0]             take,
  input logic [NUM_CORES-1:0]             ret_vec,
  input logic [NUM_CORES-1:0][NEED_W-1:0] free_regs,
  input logic [NUM_CORES-1:0][SHM_W-1:0]  free_shm
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !disp_valid);

  assert_id_in_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_bx < gx_q) && (disp_by < gy_q) && (disp_bz < gz_q));

  assert_regs_fit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> free_regs[disp_core] >= need_regs_q);

  assert_shm_fit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> free_shm[disp_core] >= need_shm_q);

  assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_led
    assert_take_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take[c] && !ret_vec[c]) |=>
        free_regs[c] == $past(free_regs[c]) - $past(need_regs_q));
    assert_regs_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      free_regs[c] <= NEED_W'(CORE_REGS));
    assert_shm_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      free_shm[c] <= SHM_W'(CORE_SHM));
  end

  assert_reject_stays_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch_error |-> !busy);

  assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_done |=> !busy);
endmodule

bind bd_dispatcher bd_dispatcher_chk #(
  .NUM_CORES(NUM_CORES), .GDIM_W(GDIM_W), .SHM_W(SHM_W), .NEED_W(NEED_W),
  .CIDX_W(CIDX_W), .CORE_REGS(CORE_REGS), .CORE_SHM(CORE_SHM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .launch_error(launch_error),
  .disp_valid(disp_valid), .disp_core(disp_core),
  .disp_bx(disp_bx), .disp_by(disp_by), .disp_bz(disp_bz),
  .launch_done(launch_done), .gx_q(gx_q), .gy_q(gy_q), .gz_q(gz_q),
  .need_regs_q(need_regs_q), .need_shm_q(need_shm_q),
  .take(take), .ret_vec(ret_vec), .free_regs(free_regs), .free_shm(free_shm)
);

// File: tb/tb_bd_dispatcher.sv
module tb_bd_dispatcher;
  localparam int NC = 4, GW = 4, BW = 4, RW = 6, SW = 10;
  localparam int CAP_R = 1024, CAP_S = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic launch_valid = 1'b0;
  logic [GW-1:0] grid_x = '0, grid_y = '0, grid_z = '0;
  logic [BW-1:0] blk_x = '0, blk_y = '0, blk_z = '0;
  logic [RW-1:0] regs_per_thread = '0;
  logic [SW-1:0] shm_per_block = '0;
  logic [NC-1:0] core_done = '0;
  logic busy, launch_error, disp_valid, launch_done;
  logic [1:0] disp_core;
  logic [GW-1:0] disp_bx, disp_by, disp_bz;

  always #4 clk = ~clk;  // 125 MHz

  bd_dispatcher dut (.*);

  int checks = 0, errors = 0;
  // reference model state
  int m_st = 0, m_err = 0;
  int m_fr[NC], m_fs[NC], m_out[NC];
  int m_gx, m_gy, m_gz, m_nr, m_ns, m_ix, m_iy, m_iz;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive, compare expected outputs, advance model
  task automatic step(input bit lv, input int gx, input int gy, input int gz,
                      input int bx, input int by, input int bz, input int rpt,
                      input int shm, input bit [NC-1:0] dn);
    int e_dv, e_core, e_done, nr;
    bit ok;
    @(negedge clk);
    launch_valid = lv; grid_x = GW'(gx); grid_y = GW'(gy); grid_z = GW'(gz);
    blk_x = BW'(bx); blk_y = BW'(by); blk_z = BW'(bz);
    regs_per_thread = RW'(rpt); shm_per_block = SW'(shm); core_done = dn;
    #1;
    e_dv = 0; e_core = 0;
    if (m_st == 1)
      for (int c = NC - 1; c >= 0; c--)
        if (m_fr[c] >= m_nr && m_fs[c] >= m_ns) begin e_dv = 1; e_core = c; end
    e_done = (m_st == 2 && m_out[0] == 0 && m_out[1] == 0 && m_out[2] == 0 && m_out[3] == 0);
    chk(busy == (m_st != 0), "R1 busy", busy, m_st != 0);
    chk(disp_valid == e_dv, "R3/R4/R5 disp_valid", disp_valid, e_dv);
    if (e_dv) begin
      chk(disp_core == e_core, "R5 disp_core", disp_core, e_core);
      chk(disp_bx == m_ix && disp_by == m_iy && disp_bz == m_iz, "R2 block index",
          disp_bx * 256 + disp_by * 16 + disp_bz, m_ix * 256 + m_iy * 16 + m_iz);
    end
    chk(launch_done == e_done, "R8 launch_done", launch_done, e_done);
    chk(launch_error == m_err, "R7 launch_error", launch_error, m_err);
    // model update for the coming edge
    for (int c = 0; c < NC; c++)  // R9: only cores with outstanding work return
      if (dn[c] && m_out[c] > 0) begin
        m_fr[c] += m_nr; m_fs[c] += m_ns; m_out[c]--;
      end
    m_err = 0;
    if (m_st == 0) begin
      if (lv) begin
        nr = bx * by * bz * rpt;
        ok = gx && gy && gz && bx && by && bz && nr <= CAP_R && shm <= CAP_S;
        if (ok) begin
          m_gx = gx; m_gy = gy; m_gz = gz; m_nr = nr; m_ns = shm;
          m_ix = 0; m_iy = 0; m_iz = 0; m_st = 1;
        end else m_err = 1;
      end
    end else if (m_st == 1) begin
      if (e_dv) begin
        m_fr[e_core] -= m_nr; m_fs[e_core] -= m_ns; m_out[e_core]++;
        if (m_ix == m_gx - 1 && m_iy == m_gy - 1 && m_iz == m_gz - 1) m_st = 2;
        else if (m_ix < m_gx - 1) m_ix++;
        else begin
          m_ix = 0;
          if (m_iy < m_gy - 1) m_iy++; else begin m_iy = 0; m_iz++; end
        end
      end
    end else if (e_done) m_st = 0;
  endtask

  task automatic idle_cycle(input bit [NC-1:0] dn);
    step(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, dn);
  endtask

  // run one launch with random completions and disturbances (R9)
  task automatic run_launch(input int gx, input int gy, input int gz, input int bx,
                            input int by, input int bz, input int rpt, input int shm,
                            input int pct);
    int n;
    bit [NC-1:0] dn;
    step(1'b1, gx, gy, gz, bx, by, bz, rpt, shm, '0);
    n = 0;
    while (m_st != 0 && n < 5000) begin
      dn = '0;
      for (int c = 0; c < NC; c++)
        if (($urandom % 100) < pct) dn[c] = 1'b1;  // may hit an empty core: R9
      if (n % 9 == 4) step(1'b1, 1, 1, 1, 1, 1, 1, 1, 1, dn);  // ignored launch: R9
      else idle_cycle(dn);
      n++;
    end
    idle_cycle('0);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin m_fr[c] = CAP_R; m_fs[c] = CAP_S; m_out[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(busy == 0 && disp_valid == 0 && launch_done == 0 && launch_error == 0,
        "R1 reset outputs", {busy, disp_valid, launch_done, launch_error}, 0);
    rst_n = 1'b1;
    idle_cycle('0);
    idle_cycle(4'b1111);  // R9: completions with nothing running
    // R3/R5: 128 regs, 100 shm -> 5 per core by shm, 8 by regs
    run_launch(3, 2, 1, 4, 4, 1, 8, 100, 20);
    // R3 boundary: exactly 1024 registers, one block per core
    run_launch(2, 2, 2, 8, 8, 2, 8, 0, 15);
    // R4 boundary: exactly 512 shared memory
    run_launch(3, 1, 2, 1, 1, 1, 1, 512, 25);
    // R2: three-axis walk with wraps
    run_launch(3, 2, 3, 2, 3, 1, 5, 60, 40);
    // R6: heavy same-cycle placement and completion
    run_launch(5, 3, 2, 2, 2, 2, 9, 170, 70);
    // R7: rejections
    step(1'b1, 2, 2, 2, 15, 15, 5, 1, 10, '0);  // 1125 registers
    idle_cycle('0); idle_cycle('0);
    step(1'b1, 2, 2, 2, 1, 1, 1, 1, 513, '0);   // shared memory too big
    idle_cycle('0); idle_cycle('0);
    step(1'b1, 2, 0, 2, 1, 1, 1, 1, 1, '0);     // zero axis
    idle_cycle(4'b0101); idle_cycle('0);
    // after rejections a normal launch still works (R8)
    run_launch(4, 4, 1, 3, 3, 3, 2, 30, 10);
    run_launch(1, 1, 1, 1, 1, 1, 0, 0, 50);
    repeat (4) idle_cycle('0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule